// File: doc/BRIEF.md
# Two-Line Level Interrupt Controller

This controller gathers 32 level-sensitive interrupt request lines and drives two request outputs: a normal line and a fast line. Each source carries an enable bit, which masks it, and a steering bit, which sends it to one output or the other. Software reaches the controller through a small word-addressed register bus. The bus has an address, a write strobe, write data and combinational read data. Over this bus software reads the unmasked source levels and the masked status seen by each output, and it programs the steering word.

Enable bits never take a plain write. One register offset turns enables on wherever the data bit is 1, and another offset turns them off wherever the data bit is 1. A data bit of 0 leaves the matching enable untouched in both cases. This lets several software agents change their own sources without a read-modify-write. Each output is the registered OR of its masked status word, so an output follows a change one clock later. One further offset stores a single access-policy bit for software. Clearing a request at its source is left to the peripheral that raised it.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable word, the steering word and the policy bit all read 0, and both irq_norm and irq_fast are low, whatever the source levels.
- R2: A read of offset 2 returns src_lvl as it is, with no masking.
- R3: A read of offset 0 returns src_lvl AND enable AND NOT steering. These are the requests sent to the normal line.
- R4: A read of offset 1 returns src_lvl AND enable AND steering. These are the requests sent to the fast line.
- R5: A write to offset 4 sets each enable bit whose data bit is 1 and leaves every other enable bit unchanged. A read of offset 4 returns the current enable word.
- R6: A write to offset 5 clears each enable bit whose data bit is 1 and leaves every other enable bit unchanged. A write of all ones disables every source. A read of offset 5 returns 0.
- R7: Offset 3 holds the steering word. It can be read and written across all 32 bits, and a steering bit of 1 sends that source to the fast line.
- R8: irq_norm is 1 exactly when the offset-0 status word was non-zero at the previous clock edge. irq_fast follows the offset-1 word in the same way, so an output changes one clock after its inputs change.
- R9: Offset 8 stores only data bit 0. A read of offset 8 returns that bit in bit 0 and returns 0 in bits 31:1.
- R10: Writes to offsets 0, 1 and 2 and to unmapped offsets (6, 7, 9 to 15) change no stored state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lvl | input | 32 | Level of each interrupt source, 1 = requesting |
| bus_addr | input | 4 | Word offset of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_norm | output | 1 | Registered OR of the normal-line status |
| irq_fast | output | 1 | Registered OR of the fast-line status |

## Verification
The masking test uses a single source pattern against enable and steering words whose bits differ by half. Each of the two status reads and each output then shows whether a bit was gated by its enable, by its steering bit, or by both. Set and clear writes use patterns that overlap the current enable word, and some use zero data, so a design that writes the word instead of setting or clearing bits is caught. When a source drops, the output is sampled both before and after the next edge, which tells the one-cycle register stage apart from a combinational path or a longer one. Writes to the status offsets and to unmapped offsets are followed by reads of every stored word.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  // Word offsets; software decodes these, so they are fixed
  localparam int unsigned OFS_NSTAT = 0;
  localparam int unsigned OFS_FSTAT = 1;
  localparam int unsigned OFS_RAW   = 2;
  localparam int unsigned OFS_STEER = 3;
  localparam int unsigned OFS_ENSET = 4;
  localparam int unsigned OFS_ENCLR = 5;
  localparam int unsigned OFS_POL   = 8;

  // Per-source gating toward the normal line
  function automatic logic gate_norm(input logic lvl, input logic en, input logic steer);
    return lvl & en & ~steer;
  endfunction

  // Per-source gating toward the fast line
  function automatic logic gate_fast(input logic lvl, input logic en, input logic steer);
    return lvl & en & steer;
  endfunction
endpackage

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs #(
  parameter int NSRC = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] steer_q,
  output logic            pol_q
);
  import irqc_pkg::*;

  // Named write events
  logic wr_set_ev, wr_clr_ev, wr_steer_ev, wr_pol_ev;
  assign wr_set_ev   = bus_we && (bus_addr == AW'(OFS_ENSET));
  assign wr_clr_ev   = bus_we && (bus_addr == AW'(OFS_ENCLR));
  assign wr_steer_ev = bus_we && (bus_addr == AW'(OFS_STEER));
  assign wr_pol_ev   = bus_we && (bus_addr == AW'(OFS_POL));

  logic [NSRC-1:0] set_m, clr_m;
  assign set_m = wr_set_ev ? bus_wdata : '0;
  assign clr_m = wr_clr_ev ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      steer_q <= '0;
      pol_q   <= 1'b0;
    end else begin
      en_q <= (en_q | set_m) & ~clr_m;
      if (wr_steer_ev) steer_q <= bus_wdata;
      if (wr_pol_ev)   pol_q   <= bus_wdata[0];
    end
  end

  // R5: a set write turns on the data bits and turns none off
  a_r5_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set_ev |=> (((en_q & $past(bus_wdata)) == $past(bus_wdata)) &&
                   (($past(en_q) & ~en_q) == '0)));
  // R6: a clear write turns off the data bits and turns none on
  a_r6_clr_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_ev |=> (((en_q & $past(bus_wdata)) == '0) &&
                   ((en_q & ~$past(en_q)) == '0)));
  // R10: with no set or clear write, the enable word holds
  a_r10_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set_ev || wr_clr_ev) |=> $stable(en_q));
  // R7: the steering word changes only through its own offset
  a_r7_steer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_steer_ev |=> $stable(steer_q));
  // R9: the policy bit changes only through its own offset
  a_r9_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pol_ev |=> $stable(pol_q));
endmodule

// File: rtl/irqc_route.sv
`timescale 1ns/1ps
module irqc_route #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] steer,
  output logic [NSRC-1:0] nstat,
  output logic [NSRC-1:0] fstat,
  output logic            irq_norm,
  output logic            irq_fast
);
  import irqc_pkg::*;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    assign nstat[gi] = gate_norm(lvl[gi], en[gi], steer[gi]);
    assign fstat[gi] = gate_fast(lvl[gi], en[gi], steer[gi]);
  end

  logic any_norm, any_fast;
  assign any_norm = |nstat;
  assign any_fast = |fstat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_norm <= 1'b0;
      irq_fast <= 1'b0;
    end else begin
      irq_norm <= any_norm;
      irq_fast <= any_fast;
    end
  end

  // R3/R4: no source reaches both lines at once
  a_r3_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (nstat & fstat) == '0);
  // R4: a masked source never shows in the fast status
  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat & ~en) == '0);
  // R8: each output follows its status one clock later
  a_r8_norm_up: assert property (@(posedge clk) disable iff (!rst_n)
    (nstat != '0) |=> irq_norm);
  a_r8_norm_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (nstat == '0) |=> !irq_norm);
  a_r8_fast_up: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat != '0) |=> irq_fast);
  a_r8_fast_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat == '0) |=> !irq_fast);
endmodule

// File: rtl/irqc_rdmux.sv
`timescale 1ns/1ps
module irqc_rdmux #(
  parameter int NSRC = 32,
  parameter int AW   = 4
) (
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] lvl,
  input  logic [NSRC-1:0] nstat,
  input  logic [NSRC-1:0] fstat,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] steer,
  input  logic            pol,
  output logic [NSRC-1:0] rdata
);
  import irqc_pkg::*;

  localparam logic [AW-1:0] A_NSTAT = AW'(OFS_NSTAT);
  localparam logic [AW-1:0] A_FSTAT = AW'(OFS_FSTAT);
  localparam logic [AW-1:0] A_RAW   = AW'(OFS_RAW);
  localparam logic [AW-1:0] A_STEER = AW'(OFS_STEER);
  localparam logic [AW-1:0] A_ENSET = AW'(OFS_ENSET);
  localparam logic [AW-1:0] A_POL   = AW'(OFS_POL);

  always_comb begin
    case (addr)
      A_NSTAT: rdata = nstat;
      A_FSTAT: rdata = fstat;
      A_RAW:   rdata = lvl;
      A_STEER: rdata = steer;
      A_ENSET: rdata = en;
      A_POL:   rdata = {{(NSRC-1){1'b0}}, pol};
      default: rdata = '0;  // clear port and unmapped offsets
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top #(
  parameter int NSRC = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_lvl,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq_norm,
  output logic            irq_fast
);
  import irqc_pkg::*;

  logic [NSRC-1:0] en_w, steer_w, nstat_w, fstat_w;
  logic            pol_w;

  irqc_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .en_q(en_w), .steer_q(steer_w), .pol_q(pol_w)
  );

  irqc_route #(.NSRC(NSRC)) u_route (
    .clk(clk), .rst_n(rst_n), .lvl(src_lvl), .en(en_w), .steer(steer_w),
    .nstat(nstat_w), .fstat(fstat_w), .irq_norm(irq_norm), .irq_fast(irq_fast)
  );

  irqc_rdmux #(.NSRC(NSRC), .AW(AW)) u_rdmux (
    .addr(bus_addr), .lvl(src_lvl), .nstat(nstat_w), .fstat(fstat_w),
    .en(en_w), .steer(steer_w), .pol(pol_w), .rdata(bus_rdata)
  );

  // R6: the clear port reads as zero
  a_r6_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(OFS_ENCLR)) |-> (bus_rdata == '0));
  // R9: only bit 0 of the policy offset is ever non-zero
  a_r9_pol_width: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(OFS_POL)) |-> (bus_rdata[NSRC-1:1] == '0));
  // R2: the raw offset mirrors the source levels
  a_r2_raw_view: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(OFS_RAW)) |-> (bus_rdata == src_lvl));
endmodule

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_norm, irq_fast;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] m_en = '0, m_steer = '0;

  always #10 clk = ~clk;  // 50 MHz

  irqc_top u0 (.clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_norm(irq_norm), .irq_fast(irq_fast));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    src_lvl = 32'hFFFF_FFFF;
    rd(4'd4, v); chk("R1 enable", v, 32'h0);
    rd(4'd3, v); chk("R1 steer", v, 32'h0);
    rd(4'd8, v); chk("R1 policy", v, 32'h0);
    @(negedge clk);
    chk("R1 irq", {30'd0, irq_norm, irq_fast}, 32'h0);
  endtask

  task automatic t_raw;
    logic [31:0] v;
    src_lvl = 32'hA5A5_0F3C;
    rd(4'd2, v); chk("R2 raw a", v, 32'hA5A5_0F3C);
    src_lvl = 32'h8000_0001;
    rd(4'd2, v); chk("R2 raw b", v, 32'h8000_0001);
  endtask

  task automatic t_set;
    logic [31:0] v;
    wr(4'd4, 32'h0000_00FF); m_en |= 32'h0000_00FF;
    wr(4'd4, 32'h0F00_0000); m_en |= 32'h0F00_0000;
    rd(4'd4, v); chk("R5 set accumulates", v, 32'h0F00_00FF);
    wr(4'd4, 32'h0);
    rd(4'd4, v); chk("R5 zero data keeps", v, m_en);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(4'd5, 32'h0000_000F); m_en &= ~32'h0000_000F;
    rd(4'd4, v); chk("R6 partial clear", v, 32'h0F00_00F0);
    rd(4'd5, v); chk("R6 clear reads zero", v, 32'h0);
    wr(4'd5, 32'hFFFF_FFFF); m_en = '0;
    rd(4'd4, v); chk("R6 clear all", v, 32'h0);
  endtask

  task automatic t_steer;
    logic [31:0] v;
    wr(4'd3, 32'hFFFF_0000); m_steer = 32'hFFFF_0000;
    rd(4'd3, v); chk("R7 steer readback", v, 32'hFFFF_0000);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(4'd4, 32'hFF00_FF00); m_en |= 32'hFF00_FF00;
    src_lvl = 32'h1234_5678;
    rd(4'd0, v); chk("R3 normal status", v, src_lvl & m_en & ~m_steer);
    rd(4'd1, v); chk("R4 fast status", v, src_lvl & m_en & m_steer);
    @(negedge clk);
    chk("R8 both high", {30'd0, irq_norm, irq_fast}, 32'h3);
    src_lvl = 32'h0000_0078;  // normal bits gated off, fast bits gone
    #1;
    chk("R8 one-cycle lag", {30'd0, irq_norm, irq_fast}, 32'h3);
    @(negedge clk);
    chk("R8 both low", {30'd0, irq_norm, irq_fast}, 32'h0);
    src_lvl = 32'h0100_0000;  // fast only
    @(negedge clk);
    chk("R8 fast only", {30'd0, irq_norm, irq_fast}, 32'h1);
  endtask

  task automatic t_pol;
    logic [31:0] v;
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, v); chk("R9 policy set", v, 32'h1);
    wr(4'd8, 32'hFFFF_FFFE);
    rd(4'd8, v); chk("R9 policy cleared", v, 32'h0);
  endtask

  task automatic t_ignore;
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd4, v); chk("R10 enable kept", v, m_en);
    rd(4'd3, v); chk("R10 steer kept", v, m_steer);
    rd(4'd8, v); chk("R10 policy kept", v, 32'h0);
    rd(4'd6, v); chk("R10 unmapped 6", v, 32'h0);
    rd(4'd15, v); chk("R10 unmapped 15", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_raw;
    t_set;
    t_clear;
    t_steer;
    t_mask;
    t_pol;
    t_ignore;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule